// File: doc/BRIEF.md
# Synchronous Shift Port (Half-Duplex, Mode 0)

This block moves bytes over a two-wire synchronous link. One pin carries a shift clock generated by the block; the other pin carries data in either direction, one direction at a time. Software starts a transmit by writing a byte into the buffer, and starts a receive by clearing the receive-done flag while receive is enabled. Bits travel least significant first. Each direction has a done flag that the block sets at the end of the eighth bit and that software clears with a pulse.

A speed input picks the bit period: 4 system clocks (fast) or 12 system clocks (standard). The speed is latched when a transfer starts. Inside each bit period the shift clock is low for the first half and high for the second half. Data is sampled, by the far end or by the block, on the rising shift-clock edge. The shift clock rests high between transfers.

The controller is a three-state machine. IDLE goes to TX on a buffer write. IDLE goes to RX on a receive-flag clear while receive is enabled and no buffer write is present. TX returns to IDLE at the end of the eighth bit period and sets the transmit-done flag. RX returns to IDLE at the end of the eighth bit period, updates the received byte and sets the receive-done flag. A buffer write has priority over a receive start in the same cycle.

Top module: `ssp_mode0_port`

## Requirements
- R1: After reset, tx_done and rx_done are 0, sclk_o is 1 and sdata_oe is 0.
- R2: With fast_mode=1 at the start of a transfer, the bit period is 4 clocks; with fast_mode=0 it is 12 clocks. In each period sclk_o is low for the first half and high for the second half. A change of fast_mode during a transfer has no effect on that transfer.
- R3: A transmit drives sdata_oe=1 for all 8 bit periods and presents buf_wdata[0] first and buf_wdata[7] last. Each bit is valid one clock before the rising sclk_o edge. It stays valid for 1 clock after that edge in fast mode and 2 clocks after it in standard mode.
- R4: tx_done rises exactly 8 bit periods after the clock edge that accepts the buffer write. It stays at 1 until a tx_flag_clr pulse, after which it reads 0.
- R5: A rx_flag_clr pulse with rx_enable=1 in IDLE starts a receive with sdata_oe=0. sdata_i is sampled at each rising sclk_o edge, first bit into rx_data[0]. rx_data is updated and rx_done rises 8 bit periods after the start edge.
- R6: A rx_flag_clr pulse with rx_enable=0 clears rx_done and starts nothing: sclk_o stays 1.
- R7: A buffer write while a transmit or receive is active is ignored: the transfer in progress keeps its data and no new transmit follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_mode | input | 1 | 1: 4 clocks per bit, 0: 12 clocks per bit |
| rx_enable | input | 1 | Allows a receive-flag clear to start a receive |
| buf_wr | input | 1 | Buffer write strobe; starts a transmit in IDLE |
| buf_wdata | input | DATA_W | Byte to transmit |
| tx_flag_clr | input | 1 | Clears the transmit-done flag |
| rx_flag_clr | input | 1 | Clears the receive-done flag; may start a receive |
| sdata_i | input | 1 | Data pin input value |
| sclk_o | output | 1 | Shift clock, high when idle |
| sdata_o | output | 1 | Data pin output value |
| sdata_oe | output | 1 | Data pin output enable, 1 only during transmit |
| rx_data | output | DATA_W | Last byte received |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |

## Verification
On every cycle the assertions check that the shift clock rests high in IDLE and that the data pin is driven only in TX. They check that transmit data does not change across a rising clock edge and that the bit counter stays inside its period. They check that a done flag rises only on leaving its own state, and that a clear without a set always empties the flag. Some behaviour can only be shown by the bench's scenarios. These are the exact bit order and data values on the pin, the full clock shape at both speeds, and the hold length after each edge. They also include the start-to-flag latency, a speed change or buffer write in mid-transfer having no effect, and a disabled receive-flag clear starting nothing.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
    typedef enum logic [1:0] {
        SSP_IDLE = 2'd0,
        SSP_TX   = 2'd1,
        SSP_RX   = 2'd2
    } ssp_state_e;
endpackage

// File: rtl/ssp_bit_timer.sv
`timescale 1ns/1ps
module ssp_bit_timer #(
    parameter int FAST_DIV  = 4,
    parameter int SLOW_DIV  = 12,
    parameter int FAST_HOLD = 1,
    parameter int SLOW_HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fast,
    input  logic run,
    output logic sclk_low,
    output logic tick_sample,
    output logic tick_shift,
    output logic tick_end
);
    localparam int MAXDIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int CW     = $clog2(MAXDIV + 1);

    logic          fast_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] period;
    logic [CW-1:0] half;
    logic [CW-1:0] shift_at;

    // speed is frozen for the whole transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            fast_q <= fast;
            cnt_q  <= '0;
        end else if (run) begin
            cnt_q <= tick_end ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        period      = fast_q ? CW'(FAST_DIV) : CW'(SLOW_DIV);
        half        = {1'b0, period[CW-1:1]};
        shift_at    = half + (fast_q ? CW'(FAST_HOLD) : CW'(SLOW_HOLD)) - 1'b1;
        tick_end    = run && (cnt_q == period - 1'b1);
        tick_sample = run && (cnt_q == half - 1'b1);
        tick_shift  = run && (cnt_q == shift_at);
        sclk_low    = run && (cnt_q < half);
    end

    // R2: the phase counter never leaves the current bit period
    a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < period));

    // R2: a period end is followed by the low half of the next period
    a_r2_low_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_end && run && !start) |=> (!run || sclk_low));
endmodule

// File: rtl/ssp_shifter.sv
`timescale 1ns/1ps
module ssp_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift_out,
    input  logic         capture,
    input  logic         sin,
    output logic         sout,
    output logic [W-1:0] word
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '1;
        end else if (load) begin
            sr_q <= load_data;
        end else if (capture) begin
            sr_q <= {sin, sr_q[W-1:1]};
        end else if (shift_out) begin
            sr_q <= {1'b1, sr_q[W-1:1]};
        end
    end

    assign sout = sr_q[0];
    assign word = sr_q;

    // R3: the register moves only on load, capture or shift requests
    a_r3_shift_only_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        !(load || capture || shift_out) |=> $stable(sr_q));
endmodule

// File: rtl/ssp_done_flags.sv
`timescale 1ns/1ps
module ssp_done_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_tx,
    input  logic clr_tx,
    input  logic set_rx,
    input  logic clr_rx,
    output logic tx_done,
    output logic rx_done
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_done <= 1'b0;
            rx_done <= 1'b0;
        end else begin
            if (set_tx)      tx_done <= 1'b1;
            else if (clr_tx) tx_done <= 1'b0;
            if (set_rx)      rx_done <= 1'b1;
            else if (clr_rx) rx_done <= 1'b0;
        end
    end

    // R4: a clear pulse with no competing set empties the transmit flag
    a_r4_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tx && !set_tx) |=> !tx_done);

    // R6: a clear pulse with no competing set empties the receive flag
    a_r6_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rx && !set_rx) |=> !rx_done);
endmodule

// File: rtl/ssp_mode0_port.sv
`timescale 1ns/1ps
module ssp_mode0_port #(
    parameter int DATA_W    = 8,
    parameter int FAST_DIV  = 4,
    parameter int SLOW_DIV  = 12,
    parameter int FAST_HOLD = 1,
    parameter int SLOW_HOLD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_mode,
    input  logic              rx_enable,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              tx_flag_clr,
    input  logic              rx_flag_clr,
    input  logic              sdata_i,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              sdata_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_done,
    output logic              rx_done
);
    import ssp_pkg::*;

    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    ssp_state_e        state_q, state_d;
    logic [BW-1:0]     bit_q;
    logic              last_bit;
    logic              tx_go, rx_go, busy;
    logic              sclk_low, tick_sample, tick_shift, tick_end;
    logic              sh_out;
    logic [DATA_W-1:0] sh_word;
    logic [DATA_W-1:0] rx_data_q;
    logic              end_tx, end_rx;

    // start decode: a write wins over a receive start
    always_comb begin
        busy     = (state_q != SSP_IDLE);
        tx_go    = (state_q == SSP_IDLE) && buf_wr;
        rx_go    = (state_q == SSP_IDLE) && !buf_wr && rx_flag_clr && rx_enable;
        last_bit = (bit_q == BW'(DATA_W - 1));
        end_tx   = (state_q == SSP_TX) && tick_end && last_bit;
        end_rx   = (state_q == SSP_RX) && tick_end && last_bit;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SSP_IDLE: begin
                if (tx_go)      state_d = SSP_TX;
                else if (rx_go) state_d = SSP_RX;
            end
            SSP_TX: if (end_tx) state_d = SSP_IDLE;
            SSP_RX: if (end_rx) state_d = SSP_IDLE;
            default:            state_d = SSP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SSP_IDLE;
        else        state_q <= state_d;
    end

    // bit counter and received byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q     <= '0;
            rx_data_q <= '0;
        end else begin
            if (tx_go || rx_go) bit_q <= '0;
            else if (busy && tick_end) bit_q <= bit_q + 1'b1;
            if (end_rx) rx_data_q <= sh_word;
        end
    end

    ssp_bit_timer #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV),
        .FAST_HOLD(FAST_HOLD),
        .SLOW_HOLD(SLOW_HOLD)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (tx_go || rx_go),
        .fast       (fast_mode),
        .run        (busy),
        .sclk_low   (sclk_low),
        .tick_sample(tick_sample),
        .tick_shift (tick_shift),
        .tick_end   (tick_end)
    );

    ssp_shifter #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_go),
        .load_data(buf_wdata),
        .shift_out((state_q == SSP_TX) && tick_shift),
        .capture  ((state_q == SSP_RX) && tick_sample),
        .sin      (sdata_i),
        .sout     (sh_out),
        .word     (sh_word)
    );

    ssp_done_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_tx (end_tx),
        .clr_tx (tx_flag_clr),
        .set_rx (end_rx),
        .clr_rx (rx_flag_clr),
        .tx_done(tx_done),
        .rx_done(rx_done)
    );

    // outputs per state
    always_comb begin
        sclk_o   = 1'b1;
        sdata_o  = 1'b1;
        sdata_oe = 1'b0;
        unique case (state_q)
            SSP_IDLE: ;
            SSP_TX: begin
                sclk_o   = !sclk_low;
                sdata_o  = sh_out;
                sdata_oe = 1'b1;
            end
            SSP_RX: sclk_o = !sclk_low;
            default: ;
        endcase
    end

    assign rx_data = rx_data_q;

    // R2: the shift clock rests high outside a transfer
    a_r2_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SSP_IDLE) |-> sclk_o);

    // R3: the data pin is driven for the whole transmit
    a_r3_drive_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SSP_TX) |-> sdata_oe);

    // R3: transmit data does not change across a rising shift-clock edge
    a_r3_stable_across_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SSP_TX) && $past(state_q == SSP_TX) && $rose(sclk_o)) |-> $stable(sdata_o));

    // R5: the data pin is released during receive
    a_r5_release_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SSP_RX) |-> !sdata_oe);

    // R4: the transmit flag rises only when a transmit finishes
    a_r4_tx_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> ($past(state_q) == SSP_TX) && (state_q == SSP_IDLE));

    // R5: the receive flag rises only when a receive finishes
    a_r5_rx_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> ($past(state_q) == SSP_RX) && (state_q == SSP_IDLE));

    // R7: a buffer write in mid-transmit does not reload the transfer
    a_r7_busy_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SSP_TX) && buf_wr && !tick_end) |=> (state_q == SSP_TX));
endmodule

// File: tb/ssp_mode0_port_test.sv
`timescale 1ns/1ps
module ssp_mode0_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fast_mode = 1'b0;
    logic       rx_enable = 1'b0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wdata = 8'h00;
    logic       tx_flag_clr = 1'b0;
    logic       rx_flag_clr = 1'b0;
    logic       sdata_i = 1'b1;
    logic       sclk_o, sdata_o, sdata_oe, tx_done, rx_done;
    logic [7:0] rx_data;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ssp_mode0_port uut (
        .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .rx_enable(rx_enable),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .tx_flag_clr(tx_flag_clr),
        .rx_flag_clr(rx_flag_clr), .sdata_i(sdata_i), .sclk_o(sclk_o),
        .sdata_o(sdata_o), .sdata_oe(sdata_oe), .rx_data(rx_data),
        .tx_done(tx_done), .rx_done(rx_done)
    );

    function automatic int per_of(input logic f);
        return f ? 4 : 12;
    endfunction

    function automatic int hold_of(input logic f);
        return f ? 1 : 2;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // transmit d; at negedge poke_k a buffer write of poke_d and a speed flip are applied
    task automatic run_tx(input logic [7:0] d, input logic f, input int poke_k,
                          input logic [7:0] poke_d);
        int   p     = per_of(f);
        int   half  = p / 2;
        int   h     = hold_of(f);
        int   total = 8 * p;
        logic trc_s [0:200];
        logic trc_d [0:200];
        int   oe_bad = 0;
        int   clk_bad = 0;
        int   sh_bad = 0;
        logic [7:0] got;
        logic early;
        @(negedge clk);
        buf_wr = 1'b1; buf_wdata = d; fast_mode = f;
        for (int k = 1; k <= total + 1; k++) begin
            @(negedge clk);
            buf_wr = 1'b0;
            trc_s[k] = sclk_o;
            trc_d[k] = sdata_o;
            if (k <= total && !sdata_oe) oe_bad++;
            if (k == total) early = tx_done;
            if (k == poke_k) begin
                buf_wr = 1'b1; buf_wdata = poke_d; fast_mode = ~f;
            end
        end
        fast_mode = f;
        for (int k = 1; k <= total; k++)
            if (trc_s[k] != (((k - 1) % p) >= half)) clk_bad++;
        for (int b = 0; b < 8; b++) begin
            got[b] = trc_d[b * p + half + 1];
            if (trc_d[b * p + half] != d[b]) sh_bad++;
            if (trc_d[b * p + half + h] != d[b]) sh_bad++;
        end
        chk(clk_bad == 0, "R2", "tx clock shape mismatches", clk_bad, 0);
        chk(got == d, "R3", "tx bits at rising edges", got, d);
        chk(sh_bad == 0, "R3", "tx setup/hold mismatches", sh_bad, 0);
        chk(oe_bad == 0, "R3", "tx cycles not driven", oe_bad, 0);
        chk(early == 1'b0, "R4", "tx_done before 8 periods", early, 0);
        chk(tx_done == 1'b1, "R4", "tx_done after 8 periods", tx_done, 1);
        chk(sclk_o && !sdata_oe, "R7", "idle after tx (no second transfer)",
            {sclk_o, sdata_oe}, 2'b10);
        repeat (3) @(negedge clk);
        chk(tx_done == 1'b1, "R4", "tx_done held", tx_done, 1);
        tx_flag_clr = 1'b1;
        @(negedge clk);
        tx_flag_clr = 1'b0;
        chk(tx_done == 1'b0, "R4", "tx_done after clear", tx_done, 0);
    endtask

    // receive bits from the bench-driven pin; optional buffer write at poke_k
    task automatic run_rx(input logic [7:0] bits, input logic f, input int poke_k);
        int   p     = per_of(f);
        int   half  = p / 2;
        int   total = 8 * p;
        int   oe_bad = 0;
        int   clk_bad = 0;
        logic early;
        @(negedge clk);
        rx_enable = 1'b1; rx_flag_clr = 1'b1; fast_mode = f; sdata_i = bits[0];
        for (int k = 1; k <= total + 1; k++) begin
            @(negedge clk);
            rx_flag_clr = 1'b0;
            buf_wr = 1'b0;
            if (k <= total) begin
                if (sdata_oe) oe_bad++;
                if (sclk_o != (((k - 1) % p) >= half)) clk_bad++;
            end
            if (k == total) early = rx_done;
            if (k < total) sdata_i = bits[k / p];
            else sdata_i = 1'($urandom % 2);
            if (k == poke_k) begin
                buf_wr = 1'b1; buf_wdata = 8'h5A;
            end
        end
        chk(clk_bad == 0, "R2", "rx clock shape mismatches", clk_bad, 0);
        chk(oe_bad == 0, "R5", "rx cycles driven", oe_bad, 0);
        chk(early == 1'b0, "R5", "rx_done before 8 periods", early, 0);
        chk(rx_done == 1'b1, "R5", "rx_done after 8 periods", rx_done, 1);
        chk(rx_data == bits, "R5", "rx_data", rx_data, bits);
        chk(sclk_o && !sdata_oe, "R7", "idle after rx", {sclk_o, sdata_oe}, 2'b10);
        // clear with receive disabled: flag drops, nothing starts
        rx_enable = 1'b0; rx_flag_clr = 1'b1;
        @(negedge clk);
        rx_flag_clr = 1'b0;
        chk(rx_done == 1'b0, "R6", "rx_done after disabled clear", rx_done, 0);
        begin
            int moved = 0;
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                if (!sclk_o || rx_done) moved++;
            end
            chk(moved == 0, "R6", "activity after disabled clear", moved, 0);
        end
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1337));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!tx_done && !rx_done, "R1", "flags after reset", {tx_done, rx_done}, 0);
        chk(sclk_o && !sdata_oe, "R1", "pins after reset", {sclk_o, sdata_oe}, 2'b10);

        // directed corners
        run_tx(8'hA5, 1'b1, -1, 8'h00);
        run_tx(8'h3C, 1'b0, -1, 8'h00);
        run_tx(8'h80, 1'b1, -1, 8'h00);
        run_tx(8'h01, 1'b0, -1, 8'h00);
        // R7 and R2: write and speed flip mid-transfer
        run_tx(8'hC3, 1'b1, 13, 8'h3C);
        run_tx(8'h96, 1'b0, 40, 8'h69);
        run_rx(8'hE1, 1'b1, -1);
        run_rx(8'h7E, 1'b0, 30);
        run_rx(8'h00, 1'b1, 5);
        run_rx(8'hFF, 1'b0, -1);

        // R6: disabled clear from idle with flag already low
        rx_flag_clr = 1'b1;
        @(negedge clk);
        rx_flag_clr = 1'b0;
        repeat (4) @(negedge clk);
        chk(sclk_o && !rx_done, "R6", "idle clear does nothing", {sclk_o, rx_done}, 2'b10);

        // random mix
        for (int i = 0; i < 24; i++) begin
            logic [7:0] d = 8'($urandom);
            logic       f = 1'($urandom % 2);
            if ($urandom % 2) run_tx(d, f, -1, 8'h00);
            else              run_rx(d, f, -1);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule